// File: doc/BRIEF.md
# Dual Data Pointer with Auto-Toggle

This block holds a pair of 16-bit memory pointers for a byte-oriented processor core. Software reads and writes each pointer one byte at a time through a small special-register port. A control register picks which pointer is active, and the active pointer is always presented on `dptr_o` for pointer-based memory operations.

The core sends three strobes. `inc_dptr_i` steps the active pointer up or down. The direction comes from a per-pointer direction bit. `dptr_op_i` marks that a pointer-based instruction has completed. If auto-toggle is enabled, this strobe flips the active selection, so block copies can alternate between a source pointer and a destination pointer with no extra instructions. `inc_ctrl_i` increments the control register. Only the select bit exists in the low part of that register, so this strobe flips the selection and leaves every other field unchanged. Opcode decode is done outside this block.

Top module: `dptr_pair`

## Requirements
- R1: After reset, both pointers are 0 and all control fields are 0. `dptr_o` reads 0 and every register address reads 0.
- R2: Register addresses on `sfr_addr_i` are:
  - 0: pointer 0 low byte
  - 1: pointer 0 high byte
  - 2: pointer 1 low byte
  - 3: pointer 1 high byte
  - 4: control register

  The control register reads as {dir1, dir0, tog, 4'b0000, sel}:
  - bit 7: direction bit for pointer 1 (dir1)
  - bit 6: direction bit for pointer 0 (dir0)
  - bit 5: auto-toggle enable (tog)
  - bits 4:1: unimplemented, read as 0
  - bit 0: select bit (sel)

  Addresses 5 to 7 read 0. Reads are combinational and reflect register state after the last clock edge.
- R3: `dptr_o` shows pointer 0 when sel is 0 and pointer 1 when sel is 1.
- R4: On `inc_dptr_i`, the active pointer changes by +1 when its direction bit is 0 and by -1 when it is 1. The result wraps modulo 2^16.
- R5: `inc_dptr_i` never changes the inactive pointer.
- R6: `inc_ctrl_i` inverts sel only. The tog and direction bits keep their values.
- R7: When tog is 1, `dptr_op_i` inverts sel at the same clock edge. When tog is 0, `dptr_op_i` has no effect.
- R8: When `inc_dptr_i` and a toggling `dptr_op_i` occur in the same cycle, the pointer that was active before the toggle is stepped.
- R9: A register write has priority in the same cycle:
  - A write to a pointer byte loads that byte and cancels that pointer's step. The pointer's other byte is unchanged.
  - A write to the control register overrides `inc_ctrl_i` and auto-toggle.
- R10: When `inc_ctrl_i` and a toggling `dptr_op_i` occur in the same cycle, the two flips cancel and sel is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_wr_i | input | 1 | Write strobe for the addressed register |
| sfr_addr_i | input | 3 | Register address (see R2) |
| sfr_wdata_i | input | 8 | Write data |
| sfr_rdata_o | output | 8 | Read data for `sfr_addr_i` |
| inc_dptr_i | input | 1 | Step the active pointer |
| dptr_op_i | input | 1 | A pointer-based instruction completed (auto-toggle trigger) |
| inc_ctrl_i | input | 1 | Increment the control register (flips sel) |
| dptr_o | output | 16 | Value of the active pointer |

## Verification
Stepping is exercised in four ways:
- Each pointer is stepped in both directions. This separates the two direction bits from each other.
- Steps cross the 0xFFFF/0x0000 boundary upward and downward. This exposes wrong wrap handling or wrong carry into the high byte.
- After a step of the active pointer, the inactive pointer is read back. This shows whether the step leaked to the other pointer.
- Strobes are driven in combination: step with toggle, write with step, write with control increment, and control increment with toggle. These cases pin down which pointer is stepped and which source wins when several act in the same cycle.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  typedef enum logic [2:0] {
    SFR_P0_LO = 3'd0,
    SFR_P0_HI = 3'd1,
    SFR_P1_LO = 3'd2,
    SFR_P1_HI = 3'd3,
    SFR_CTRL  = 3'd4
  } sfr_sel_e;

  localparam int CTRL_SEL_BIT  = 0;
  localparam int CTRL_TOG_BIT  = 5;
  localparam int CTRL_DIR0_BIT = 6;
endpackage

// File: rtl/dptr_word.sv
module dptr_word #(
  parameter int BYTE_W = 8,
  parameter int NB     = 2,
  localparam int PTR_W = BYTE_W * NB,
  localparam int BI_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BI_W-1:0]   wr_byte_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              step_en_i,
  input  logic              step_dn_i,
  output logic [PTR_W-1:0]  ptr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (wr_en_i) begin
      // byte write wins over a step
      for (int b = 0; b < NB; b++) begin
        if (wr_byte_i == BI_W'(b)) ptr_d[b*BYTE_W +: BYTE_W] = wr_data_i;
      end
    end else if (step_en_i) begin
      ptr_d = step_dn_i ? ptr_q - PTR_W'(1) : ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
  import dptr_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int NUM_PTR = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [BYTE_W-1:0]  wr_data_i,
  input  logic               inc_ctrl_i,
  input  logic               dptr_op_i,
  output logic               sel_o,
  output logic               tog_o,
  output logic [NUM_PTR-1:0] dir_o,
  output logic [BYTE_W-1:0]  rd_o
);
  logic               sel_q, tog_q;
  logic [NUM_PTR-1:0] dir_q;
  logic               flip;

  // both flip sources in one cycle cancel out
  assign flip = inc_ctrl_i ^ (dptr_op_i & tog_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      tog_q <= 1'b0;
      dir_q <= '0;
    end else if (wr_en_i) begin
      sel_q <= wr_data_i[CTRL_SEL_BIT];
      tog_q <= wr_data_i[CTRL_TOG_BIT];
      dir_q <= wr_data_i[CTRL_DIR0_BIT +: NUM_PTR];
    end else if (flip) begin
      sel_q <= ~sel_q;
    end
  end

  always_comb begin
    rd_o = '0;
    rd_o[CTRL_SEL_BIT]             = sel_q;
    rd_o[CTRL_TOG_BIT]             = tog_q;
    rd_o[CTRL_DIR0_BIT +: NUM_PTR] = dir_q;
  end

  assign sel_o = sel_q;
  assign tog_o = tog_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/dptr_pair.sv
module dptr_pair
  import dptr_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int PTR_W  = 2 * BYTE_W,
  localparam int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sfr_wr_i,
  input  logic [ADDR_W-1:0] sfr_addr_i,
  input  logic [BYTE_W-1:0] sfr_wdata_i,
  output logic [BYTE_W-1:0] sfr_rdata_o,
  input  logic              inc_dptr_i,
  input  logic              dptr_op_i,
  input  logic              inc_ctrl_i,
  output logic [PTR_W-1:0]  dptr_o
);
  localparam int NUM_PTR = 2;

  logic [PTR_W-1:0]   ptr_q [NUM_PTR];
  logic               sel, tog;
  logic [NUM_PTR-1:0] dir;
  logic [BYTE_W-1:0]  ctrl_rd;
  logic               ctrl_wr;

  assign ctrl_wr = sfr_wr_i && (sfr_addr_i == SFR_CTRL);

  dptr_ctrl #(.BYTE_W(BYTE_W), .NUM_PTR(NUM_PTR)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (ctrl_wr),
    .wr_data_i  (sfr_wdata_i),
    .inc_ctrl_i (inc_ctrl_i),
    .dptr_op_i  (dptr_op_i),
    .sel_o      (sel),
    .tog_o      (tog),
    .dir_o      (dir),
    .rd_o       (ctrl_rd)
  );

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_ptr
    logic wr_k;
    assign wr_k = sfr_wr_i && !sfr_addr_i[2] && (sfr_addr_i[1] == 1'(k));
    dptr_word #(.BYTE_W(BYTE_W), .NB(2)) word_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_k),
      .wr_byte_i (sfr_addr_i[0]),
      .wr_data_i (sfr_wdata_i),
      .step_en_i (inc_dptr_i && (sel == 1'(k))),
      .step_dn_i (dir[k]),
      .ptr_o     (ptr_q[k])
    );
  end

  always_comb begin
    unique case (sfr_addr_i)
      SFR_P0_LO: sfr_rdata_o = ptr_q[0][BYTE_W-1:0];
      SFR_P0_HI: sfr_rdata_o = ptr_q[0][PTR_W-1:BYTE_W];
      SFR_P1_LO: sfr_rdata_o = ptr_q[1][BYTE_W-1:0];
      SFR_P1_HI: sfr_rdata_o = ptr_q[1][PTR_W-1:BYTE_W];
      SFR_CTRL:  sfr_rdata_o = ctrl_rd;
      default:   sfr_rdata_o = '0;
    endcase
  end

  assign dptr_o = sel ? ptr_q[1] : ptr_q[0];
endmodule

// File: rtl/dptr_pair_chk.sv
module dptr_pair_chk #(
  parameter int BYTE_W = 8,
  localparam int PTR_W = 2 * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sfr_wr_i,
  input logic [2:0]        sfr_addr_i,
  input logic [BYTE_W-1:0] sfr_wdata_i,
  input logic              inc_dptr_i,
  input logic              dptr_op_i,
  input logic              inc_ctrl_i,
  input logic [PTR_W-1:0]  ptr0_i,
  input logic [PTR_W-1:0]  ptr1_i,
  input logic              sel_i,
  input logic              tog_i,
  input logic [1:0]        dir_i
);
  logic wr_p0, wr_p1, wr_ctl;
  assign wr_p0  = sfr_wr_i && (sfr_addr_i[2:1] == 2'b00);
  assign wr_p1  = sfr_wr_i && (sfr_addr_i[2:1] == 2'b01);
  assign wr_ctl = sfr_wr_i && (sfr_addr_i == 3'd4);

  // R4
  step_up0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_dptr_i && !sel_i && !dir_i[0] && !wr_p0 |=> ptr0_i == $past(ptr0_i) + PTR_W'(1));

  // R4
  step_dn1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_dptr_i && sel_i && dir_i[1] && !wr_p1 |=> ptr1_i == $past(ptr1_i) - PTR_W'(1));

  // R5
  hold_inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_dptr_i && !sel_i && !wr_p1 |=> $stable(ptr1_i));

  // R6
  ctrl_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_ctrl_i && !dptr_op_i && !wr_ctl |=> (sel_i != $past(sel_i)) && $stable(tog_i) && $stable(dir_i));

  // R7
  auto_tog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dptr_op_i && tog_i && !inc_ctrl_i && !wr_ctl |=> sel_i != $past(sel_i));

  // R9
  wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_wr_i && (sfr_addr_i == 3'd0) |=>
      (ptr0_i[BYTE_W-1:0] == $past(sfr_wdata_i)) && (ptr0_i[PTR_W-1:BYTE_W] == $past(ptr0_i[PTR_W-1:BYTE_W])));

  // R10
  flip_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_ctrl_i && dptr_op_i && tog_i && !wr_ctl |=> $stable(sel_i));
endmodule

bind dptr_pair dptr_pair_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sfr_wr_i    (sfr_wr_i),
  .sfr_addr_i  (sfr_addr_i),
  .sfr_wdata_i (sfr_wdata_i),
  .inc_dptr_i  (inc_dptr_i),
  .dptr_op_i   (dptr_op_i),
  .inc_ctrl_i  (inc_ctrl_i),
  .ptr0_i      (ptr_q[0]),
  .ptr1_i      (ptr_q[1]),
  .sel_i       (sel),
  .tog_i       (tog),
  .dir_i       (dir)
);

// File: tb/dptr_pair_tb_top.sv
`timescale 1ns/1ps
module dptr_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sfr_wr = 1'b0;
  logic [2:0]  sfr_addr = 3'd0;
  logic [7:0]  sfr_wdata = 8'd0;
  logic [7:0]  sfr_rdata;
  logic        inc_dptr = 1'b0, dptr_op = 1'b0, inc_ctrl = 1'b0;
  logic [15:0] dptr;

  always #10 clk = ~clk;

  dptr_pair dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sfr_wr_i(sfr_wr), .sfr_addr_i(sfr_addr),
    .sfr_wdata_i(sfr_wdata), .sfr_rdata_o(sfr_rdata), .inc_dptr_i(inc_dptr),
    .dptr_op_i(dptr_op), .inc_ctrl_i(inc_ctrl), .dptr_o(dptr)
  );

  typedef struct {
    logic [15:0] dptr;
    logic [7:0]  rd;
    string       req;
  } item_t;
  item_t exp_q[$];

  int checks = 0, fails = 0;

  // reference model
  logic [15:0] m_p [2] = '{16'd0, 16'd0};
  logic        m_sel = 1'b0, m_tog = 1'b0;
  logic [1:0]  m_dir = 2'b00;

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_p[0][7:0];
      3'd1: return m_p[0][15:8];
      3'd2: return m_p[1][7:0];
      3'd3: return m_p[1][15:8];
      3'd4: return {m_dir[1], m_dir[0], m_tog, 4'b0000, m_sel};
      default: return 8'h00;
    endcase
  endfunction

  task automatic drive(input logic wr, input logic [2:0] a, input logic [7:0] d,
                       input logic inc, input logic op, input logic ic, input string req);
    item_t it;
    logic  old_sel;
    sfr_wr = wr; sfr_addr = a; sfr_wdata = d;
    inc_dptr = inc; dptr_op = op; inc_ctrl = ic;
    @(posedge clk);
    old_sel = m_sel;
    for (int k = 0; k < 2; k++) begin
      if (wr && !a[2] && (a[1] == 1'(k))) begin
        if (a[0]) m_p[k][15:8] = d; else m_p[k][7:0] = d;
      end else if (inc && (old_sel == 1'(k))) begin
        m_p[k] = m_dir[k] ? m_p[k] - 16'd1 : m_p[k] + 16'd1;
      end
    end
    if (wr && a == 3'd4) begin
      m_sel = d[0]; m_tog = d[5]; m_dir = d[7:6];
    end else begin
      m_sel = m_sel ^ ic ^ (op & m_tog);
    end
    it.dptr = m_sel ? m_p[1] : m_p[0];
    it.rd   = m_read(a);
    it.req  = req;
    exp_q.push_back(it);
    #7;
    sfr_wr = 1'b0; inc_dptr = 1'b0; dptr_op = 1'b0; inc_ctrl = 1'b0;
  endtask

  // monitor: compares mid-cycle, after the edge that produced the result
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      if (dptr !== it.dptr) begin
        fails++;
        $display("FAIL %s dptr_o actual=%h expected=%h", it.req, dptr, it.dptr);
      end
      checks++;
      if (sfr_rdata !== it.rd) begin
        fails++;
        $display("FAIL %s sfr_rdata_o actual=%h expected=%h", it.req, sfr_rdata, it.rd);
      end
    end
  end

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    @(posedge clk); #7;
    // R1 reset state
    drive(0, 3'd0, 8'h00, 0, 0, 0, "R1");
    drive(0, 3'd4, 8'h00, 0, 0, 0, "R1");
    drive(0, 3'd3, 8'h00, 0, 0, 0, "R1");
    // R2 byte writes and readback
    drive(1, 3'd0, 8'hFE, 0, 0, 0, "R2");
    drive(1, 3'd1, 8'hFF, 0, 0, 0, "R2");
    drive(0, 3'd1, 8'h00, 0, 0, 0, "R2");
    // R4 increment across wrap
    drive(0, 3'd0, 8'h00, 1, 0, 0, "R4");
    drive(0, 3'd1, 8'h00, 1, 0, 0, "R4");
    // R4 decrement pointer 0 back across wrap
    drive(1, 3'd4, 8'h40, 0, 0, 0, "R2");
    drive(0, 3'd0, 8'h00, 1, 0, 0, "R4");
    // R3 switch to pointer 1
    drive(1, 3'd2, 8'h34, 0, 0, 0, "R2");
    drive(1, 3'd3, 8'h12, 0, 0, 0, "R2");
    drive(1, 3'd4, 8'h41, 0, 0, 0, "R3");
    // R4 pointer 1 increments; R5 pointer 0 unchanged
    drive(0, 3'd0, 8'h00, 1, 0, 0, "R5");
    drive(0, 3'd1, 8'h00, 1, 0, 0, "R5");
    // R4 pointer 1 decrements with dir1
    drive(1, 3'd4, 8'h81, 0, 0, 0, "R2");
    drive(0, 3'd2, 8'h00, 1, 0, 0, "R4");
    drive(1, 3'd2, 8'h00, 0, 0, 0, "R2");
    drive(1, 3'd3, 8'h00, 0, 0, 0, "R2");
    drive(0, 3'd3, 8'h00, 1, 0, 0, "R4");
    // R6 control increment flips only sel
    drive(0, 3'd4, 8'h00, 0, 0, 1, "R6");
    drive(0, 3'd4, 8'h00, 0, 0, 1, "R6");
    // R7 toggle disabled then enabled
    drive(0, 3'd4, 8'h00, 0, 1, 0, "R7");
    drive(1, 3'd4, 8'h20, 0, 0, 0, "R7");
    drive(0, 3'd4, 8'h00, 0, 1, 0, "R7");
    drive(0, 3'd4, 8'h00, 0, 1, 0, "R7");
    // R8 step + toggle: old active (pointer 0) steps
    drive(0, 3'd0, 8'h00, 1, 1, 0, "R8");
    drive(0, 3'd2, 8'h00, 1, 1, 0, "R8");
    // R9 write beats step on the same pointer
    drive(1, 3'd4, 8'h21, 0, 0, 0, "R9");
    drive(1, 3'd2, 8'h55, 1, 0, 0, "R9");
    drive(0, 3'd3, 8'h00, 0, 0, 0, "R9");
    // R9 control write beats control increment and toggle
    drive(1, 3'd4, 8'h21, 0, 1, 1, "R9");
    // R10 increment and toggle cancel
    drive(0, 3'd4, 8'h00, 0, 1, 1, "R10");
    // R2 unused addresses
    drive(0, 3'd5, 8'h00, 0, 0, 0, "R2");
    drive(0, 3'd6, 8'h00, 0, 0, 0, "R2");
    drive(0, 3'd7, 8'h00, 0, 0, 0, "R2");
    while (exp_q.size() > 0) @(posedge clk);
    #8;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule